// File: doc/BRIEF.md
# Reset and Configuration Boot Sequencer

This block brings a clocking device out of reset and fills its configuration register file before anything else is allowed to touch it. Two reset sources feed it: an internal power-on reset, which is active high, and an external reset pin, which is active low. The external pin first passes through a short glitch filter. While either source is active, every register is held at zero, the clock-output enables are off, the GPIO pins are left as inputs, and the interrupt line is released.

When the later of the two sources lets go, the sequencer copies an initial block of registers from a one-time-programmable ROM. One bit in that block then selects where the remaining registers come from. They are either fetched one byte at a time from an external serial EEPROM, through a request/response port, or read from the same ROM. The EEPROM path is never taken while the host interface is strapped to SPI. If the EEPROM refuses a byte or stays silent, the sequencer reloads the remaining registers from the ROM and flags a boot error.

A single-cycle done pulse marks the end of loading. After it, the host register port starts answering and the PLL lock phase begins.

Top module: `boot_seq`

## Requirements
- R1: Reset is active while `por` is high or while `ext_rst_n` has been low for at least two consecutive clock samples. Reset ends only once both sources are released. An external low that starts during `por` keeps the block in reset after `por` falls, for as long as the pin stays low.
- R2: A low pulse on `ext_rst_n` lasting a single clock cycle has no effect. Loaded and host-written registers, and the output enables, are kept.
- R3: While in reset and on the first cycle after it, `clk_oe` and `gpio_oe` are all zero (the GPIO pins act as inputs), `irq_n` is 1, `pll_start` is 0, and every register and the interrupt status are cleared to zero.
- R4: After reset, registers 0 to INIT_CNT-1 (0 to 3 by default) are loaded from the ROM. The ROM holds `(29*index + OTP_SEED) mod 256` at each index.
- R5: Bit 7 of register 2 selects the source of registers INIT_CNT to REG_CNT-1. A 1 selects the EEPROM at 7-bit device address 0x50, shown on `ee_dev`. A 0 selects the ROM.
- R6: When `spi_mode` is 1, `ee_req` is never raised, and all registers come from the ROM.
- R7: For each EEPROM byte, `ee_req` stays high with `ee_addr` equal to the register index until `ee_ack` (which stores `ee_rdata`) or `ee_nack` arrives.
- R8: Before the done pulse, host requests get no `host_ack` and writes are dropped. Afterwards, a request is acknowledged one cycle later. `host_rdata` returns the register value from before any write, and a write updates the register.
- R9: An `ee_nack`, or EE_TIMEOUT cycles (64 by default) without a response, reloads registers INIT_CNT and up from the ROM and sets `boot_err`. `irq_n` goes low when `boot_err` is set and bit 0 of register 6 is 1.
- R10: `boot_done` is high for exactly one cycle when loading ends. From the next cycle, `pll_start` is held high until reset.
- R11: After boot, `clk_oe` follows register 4 and `gpio_oe` follows register 5, including later host writes to those registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por | input | 1 | Power-on reset, active high |
| ext_rst_n | input | 1 | External reset, active low, glitch filtered |
| spi_mode | input | 1 | Host interface strap; 1 disables the EEPROM path |
| ee_req | output | 1 | EEPROM byte request |
| ee_dev | output | 7 | EEPROM bus device address |
| ee_addr | output | AW | Register index being fetched |
| ee_ack | input | 1 | Byte returned, one cycle |
| ee_nack | input | 1 | Byte refused, one cycle |
| ee_rdata | input | 8 | Returned byte |
| host_req | input | 1 | Host register access request |
| host_we | input | 1 | Host write when 1 |
| host_addr | input | AW | Host register index |
| host_wdata | input | 8 | Host write data |
| host_ack | output | 1 | Access acknowledged |
| host_rdata | output | 8 | Read data |
| clk_oe | output | N_OUT | Clock output enables |
| gpio_oe | output | N_GPIO | GPIO output drive enables |
| irq_n | output | 1 | Interrupt, active low |
| boot_err | output | 1 | EEPROM load failed, ROM fallback used |
| boot_done | output | 1 | One-cycle end-of-load pulse |
| pll_start | output | 1 | PLL lock phase enabled |

## Verification
The properties take several things for granted about the inputs. `spi_mode` changes only while reset is active. `ee_ack` and `ee_nack` are single-cycle pulses that arrive only while `ee_req` is high, and never together. `por` is the reset that disables every property. The bench's EEPROM model answers only an open request, after a random delay of zero to three cycles, and clears its response on the following cycle. Its refusing mode nacks at a chosen index, and its silent mode never answers. The bench changes the strap only while `por` is high, and every host access is a one-cycle request that it drives on the falling clock edge.

// File: rtl/boot_seq.sv
module boot_seq #(
  parameter int         REG_CNT    = 16,
  parameter int         INIT_CNT   = 4,
  parameter int         FLAG_IDX   = 2,
  parameter int         FLAG_BIT   = 7,
  parameter int         OE_IDX     = 4,
  parameter int         GPIO_IDX   = 5,
  parameter int         INT_IDX    = 6,
  parameter int         N_OUT      = 8,
  parameter int         N_GPIO     = 8,
  parameter logic [6:0] EE_DEV     = 7'h50,
  parameter int         EE_TIMEOUT = 64,
  parameter int         RST_FILT   = 2,
  parameter logic [7:0] OTP_SEED   = 8'h60,
  localparam int        AW = $clog2(REG_CNT),
  localparam int        TW = $clog2(EE_TIMEOUT + 1),
  localparam int        FW = $clog2(RST_FILT + 1)
) (
  input  logic              clk,
  input  logic              por,
  input  logic              ext_rst_n,
  input  logic              spi_mode,
  output logic              ee_req,
  output logic [6:0]        ee_dev,
  output logic [AW-1:0]     ee_addr,
  input  logic              ee_ack,
  input  logic              ee_nack,
  input  logic [7:0]        ee_rdata,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [AW-1:0]     host_addr,
  input  logic [7:0]        host_wdata,
  output logic              host_ack,
  output logic [7:0]        host_rdata,
  output logic [N_OUT-1:0]  clk_oe,
  output logic [N_GPIO-1:0] gpio_oe,
  output logic              irq_n,
  output logic              boot_err,
  output logic              boot_done,
  output logic              pll_start
);

  typedef enum logic [2:0] {S_RST, S_INIT, S_PICK, S_REST, S_EE, S_DONE, S_RUN} st_t;

  st_t           state;
  logic [AW-1:0] idx;
  logic [TW-1:0] tmr;
  logic [FW-1:0] lo_cnt;
  logic          err;
  logic          rst;
  logic [7:0]    regs [REG_CNT];

  function automatic logic [7:0] otp_byte(input logic [AW-1:0] a);
    logic [15:0] p;
    p = 16'(a) * 16'd29;
    return p[7:0] + OTP_SEED;
  endfunction

  always_ff @(posedge clk) begin
    if (por)
      lo_cnt <= ext_rst_n ? '0 : FW'(RST_FILT);
    else if (ext_rst_n)
      lo_cnt <= '0;
    else if (lo_cnt != FW'(RST_FILT))
      lo_cnt <= lo_cnt + 1'b1;
  end

  assign rst = por | (lo_cnt == FW'(RST_FILT));

  wire last_idx = (idx == AW'(REG_CNT - 1));
  wire tmo      = (tmr == TW'(EE_TIMEOUT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_RST;
      idx        <= '0;
      tmr        <= '0;
      err        <= 1'b0;
      host_ack   <= 1'b0;
      host_rdata <= '0;
      for (int i = 0; i < REG_CNT; i++) regs[i] <= '0;
    end else begin
      host_ack <= 1'b0;
      case (state)
        S_RST: begin
          idx   <= '0;
          state <= S_INIT;
        end
        S_INIT: begin
          regs[idx] <= otp_byte(idx);
          if (idx == AW'(INIT_CNT - 1)) state <= S_PICK;
          else idx <= idx + 1'b1;
        end
        S_PICK: begin
          idx   <= AW'(INIT_CNT);
          tmr   <= '0;
          state <= (regs[FLAG_IDX][FLAG_BIT] && !spi_mode) ? S_EE : S_REST;
        end
        S_REST: begin
          regs[idx] <= otp_byte(idx);
          if (last_idx) state <= S_DONE;
          else idx <= idx + 1'b1;
        end
        S_EE: begin
          if (ee_ack) begin
            regs[idx] <= ee_rdata;
            tmr       <= '0;
            if (last_idx) state <= S_DONE;
            else idx <= idx + 1'b1;
          end else if (ee_nack || tmo) begin
            err   <= 1'b1;
            idx   <= AW'(INIT_CNT);
            state <= S_REST;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_DONE: state <= S_RUN;
        S_RUN: begin
          host_ack <= host_req;
          if (host_req) begin
            host_rdata <= regs[host_addr];
            if (host_we) regs[host_addr] <= host_wdata;
          end
        end
        default: state <= S_RST;
      endcase
    end
  end

  assign ee_req    = (state == S_EE);
  assign ee_addr   = idx;
  assign ee_dev    = EE_DEV;
  assign pll_start = (state == S_RUN);
  assign boot_done = (state == S_DONE);
  assign boot_err  = err;
  assign clk_oe    = pll_start ? regs[OE_IDX][N_OUT-1:0]    : '0;
  assign gpio_oe   = pll_start ? regs[GPIO_IDX][N_GPIO-1:0] : '0;
  assign irq_n     = !(err && regs[INT_IDX][0]);

endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk #(
  parameter int N_OUT  = 8,
  parameter int N_GPIO = 8,
  parameter int AW     = 4
) (
  input logic              clk,
  input logic              por,
  input logic              rst,
  input logic              spi_mode,
  input logic              ee_req,
  input logic [AW-1:0]     ee_addr,
  input logic              ee_ack,
  input logic              ee_nack,
  input logic              host_ack,
  input logic              pll_start,
  input logic              boot_done,
  input logic              boot_err,
  input logic              irq_n,
  input logic [N_OUT-1:0]  clk_oe,
  input logic [N_GPIO-1:0] gpio_oe
);

  a_r3_quiet_after_reset: assert property (@(posedge clk) disable iff (por)
    rst |=> (clk_oe == '0 && gpio_oe == '0 && irq_n && !pll_start && !boot_err));

  a_r8_host_gated: assert property (@(posedge clk) disable iff (por)
    !pll_start |=> !host_ack);

  a_r6_spi_no_eeprom: assert property (@(posedge clk) disable iff (por)
    (spi_mode && !ee_req) |=> !ee_req);

  a_r10_done_single: assert property (@(posedge clk) disable iff (por)
    (boot_done && !rst) |=> (!boot_done && pll_start));

  a_r9_err_on_nack: assert property (@(posedge clk) disable iff (por)
    (ee_req && ee_nack && !ee_ack && !rst) |=> boot_err);

  a_r7_request_held: assert property (@(posedge clk) disable iff (por)
    (ee_req && !ee_ack && !ee_nack && !rst) |=> ((ee_req && $stable(ee_addr)) || boot_err));

endmodule

bind boot_seq boot_seq_chk #(.N_OUT(N_OUT), .N_GPIO(N_GPIO), .AW(AW)) chk (
  .clk(clk), .por(por), .rst(rst), .spi_mode(spi_mode), .ee_req(ee_req),
  .ee_addr(ee_addr), .ee_ack(ee_ack), .ee_nack(ee_nack), .host_ack(host_ack),
  .pll_start(pll_start), .boot_done(boot_done), .boot_err(boot_err),
  .irq_n(irq_n), .clk_oe(clk_oe), .gpio_oe(gpio_oe)
);

// File: tb/boot_seq_test.sv
`timescale 1ns/1ps
module boot_seq_test;
  localparam int AW = 4;
  localparam int NR = 16;

  logic clk = 0, por = 1, ext_rst_n = 1, spi_mode = 0;
  logic ee_ack = 0, ee_nack = 0;
  logic [7:0] ee_rdata = 0;
  logic host_req = 0, host_we = 0;
  logic [AW-1:0] host_addr = 0;
  logic [7:0] host_wdata = 0;

  logic ee_req, host_ack, irq_n, boot_err, boot_done, pll_start;
  logic [6:0] ee_dev;
  logic [AW-1:0] ee_addr;
  logic [7:0] host_rdata, clk_oe, gpio_oe;

  logic ee_req2, host_ack2, irq_n2, boot_err2, boot_done2, pll_start2;
  logic [6:0] ee_dev2;
  logic [AW-1:0] ee_addr2;
  logic [7:0] host_rdata2, clk_oe2, gpio_oe2;

  boot_seq uut (
    .clk, .por, .ext_rst_n, .spi_mode, .ee_req, .ee_dev, .ee_addr, .ee_ack, .ee_nack,
    .ee_rdata, .host_req, .host_we, .host_addr, .host_wdata, .host_ack, .host_rdata,
    .clk_oe, .gpio_oe, .irq_n, .boot_err, .boot_done, .pll_start);

  boot_seq #(.OTP_SEED(8'h10)) uut2 (
    .clk, .por, .ext_rst_n, .spi_mode, .ee_req(ee_req2), .ee_dev(ee_dev2), .ee_addr(ee_addr2),
    .ee_ack(1'b0), .ee_nack(1'b0), .ee_rdata(8'h00), .host_req, .host_we, .host_addr,
    .host_wdata, .host_ack(host_ack2), .host_rdata(host_rdata2), .clk_oe(clk_oe2),
    .gpio_oe(gpio_oe2), .irq_n(irq_n2), .boot_err(boot_err2), .boot_done(boot_done2),
    .pll_start(pll_start2));

  always #2.5 clk = ~clk;

  int nchk = 0, nfail = 0, done_cnt = 0;
  bit finished = 0, ee_seen = 0, ee2_seen = 0, dev_bad = 0;
  int ee_mode = 0, nack_idx = 8, wait_cnt = 0, lat = 0;

  function automatic logic [7:0] otp_exp(input logic [7:0] seed, input int a);
    return 8'((a * 29 + seed) % 256);
  endfunction
  function automatic logic [7:0] ee_byte(input int a);
    return 8'((a * 71) % 256) ^ 8'hA5;
  endfunction
  function automatic logic [7:0] exp_reg(input int a, input bit spi, input int mode);
    if (a < 4 || spi || mode != 0) return otp_exp(8'h60, a);
    return ee_byte(a);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (boot_done) done_cnt++;
    if (ee_req) ee_seen = 1;
    if (ee_req2) ee2_seen = 1;
    if (ee_req && ee_dev != 7'h50) dev_bad = 1;
    if (ee_ack || ee_nack) begin
      ee_ack = 0; ee_nack = 0; wait_cnt = 0;
    end else if (ee_req) begin
      if (ee_mode == 1 && int'(ee_addr) == nack_idx) ee_nack = 1;
      else if (ee_mode != 2) begin
        if (wait_cnt >= lat) begin
          ee_ack = 1; ee_rdata = ee_byte(int'(ee_addr));
          wait_cnt = 0; lat = $urandom_range(0, 3);
        end else wait_cnt++;
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_op(input bit we, input int a, input logic [7:0] d, output logic [7:0] r, output logic ack);
    host_req = 1; host_we = we; host_addr = AW'(a); host_wdata = d;
    @(negedge clk);
    host_req = 0; host_we = 0;
    r = host_rdata; ack = host_ack;
  endtask

  task automatic wait_done();
    bit got = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (boot_done) begin got = 1; break; end
    end
    check("R10 done pulse", int'(got), 1);
    tick(1);
    check("R10 pulse single", int'(boot_done), 0);
    check("R10 pll_start", int'(pll_start), 1);
  endtask

  task automatic boot(input bit spi, input int mode, input int nidx);
    por = 1; ext_rst_n = 1; spi_mode = spi; ee_mode = mode; nack_idx = nidx;
    wait_cnt = 0; ee_seen = 0; ee2_seen = 0; dev_bad = 0;
    tick(3);
    check("R3 clk_oe in reset", int'(clk_oe), 0);
    check("R3 gpio_oe in reset", int'(gpio_oe), 0);
    check("R3 irq_n in reset", int'(irq_n), 1);
    check("R3 pll_start in reset", int'(pll_start), 0);
    por = 0;
    begin
      logic [7:0] r; logic a;
      host_op(1, 4, 8'hFF, r, a);
      check("R8 no ack during load", int'(a), 0);
      check("R8 no ack during load uut2", int'(host_ack2), 0);
    end
    wait_done();
  endtask

  task automatic verify(input bit spi, input int mode);
    logic [7:0] r; logic a;
    bit err_exp;
    err_exp = !spi && mode != 0;
    for (int i = 0; i < NR; i++) begin
      host_op(0, i, 8'h00, r, a);
      check(i < 4 ? "R4 ack" : "R8 ack", int'(a), 1);
      check(i < 4 ? "R4 rom reg" : (err_exp ? "R9 fallback reg" : (spi ? "R6 rom reg" : "R5 eeprom reg")),
            int'(r), int'(exp_reg(i, spi, mode)));
      check("R5 flag clear uut2 rom", int'(host_rdata2), int'(otp_exp(8'h10, i)));
    end
    check("R9 boot_err", int'(boot_err), int'(err_exp));
    check("R6 eeprom used", int'(ee_seen), int'(!spi));
    check("R5 flag clear no eeprom", int'(ee2_seen), 0);
    check("R5 device address", int'(dev_bad), 0);
    check("R11 clk_oe", int'(clk_oe), int'(exp_reg(4, spi, mode)));
    check("R11 gpio_oe", int'(gpio_oe), int'(exp_reg(5, spi, mode)));
    check("R9 irq_n", int'(irq_n), int'(!(err_exp && exp_reg(6, spi, mode)[0])));
  endtask

  initial begin
    #(5.0 * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog actual=hung expected=finish");
    summary();
  end

  initial begin
    logic [7:0] r; logic a;
    void'($urandom(32'd1234));

    boot(0, 0, 8);
    verify(0, 0);

    host_op(1, 4, 8'h3C, r, a);
    check("R8 write ack", int'(a), 1);
    check("R8 read-before-write", int'(r), int'(ee_byte(4)));
    tick(1);
    check("R11 clk_oe follows write", int'(clk_oe), 8'h3C);

    ext_rst_n = 0; tick(1); ext_rst_n = 1; tick(3);
    check("R2 short pulse pll_start", int'(pll_start), 1);
    check("R2 short pulse keeps reg", int'(clk_oe), 8'h3C);

    ext_rst_n = 0; tick(2); ext_rst_n = 1; tick(1);
    check("R1 ext reset pll_start", int'(pll_start), 0);
    check("R3 ext reset clk_oe", int'(clk_oe), 0);
    wait_done();
    verify(0, 0);

    begin
      int d0;
      por = 1; ext_rst_n = 0; tick(3); por = 0;
      d0 = done_cnt; ee_seen = 0;
      tick(20);
      check("R1 held by later source", int'(pll_start), 0);
      check("R1 no load while held", done_cnt - d0 + int'(ee_seen), 0);
      ext_rst_n = 1;
      wait_done();
    end

    boot(1, 0, 8);
    verify(1, 0);

    boot(0, 2, 8);
    verify(0, 2);
    host_op(1, 6, 8'h01, r, a);
    tick(1);
    check("R9 irq low when enabled", int'(irq_n), 0);

    boot(0, 1, 9);
    verify(0, 1);

    for (int k = 0; k < 6; k++) begin
      bit s; int m;
      s = 1'($urandom_range(0, 1));
      m = $urandom_range(0, 2);
      boot(s, m, $urandom_range(4, 15));
      verify(s, m);
    end

    summary();
  end
endmodule